// File: doc/BRIEF.md
# Monitoring Processor Pool Allocator

This block manages a fixed pool of performance-monitoring processor slots shared by many connections. A requester presents an activate or deactivate request that carries a connection index. For an activation, the allocator binds the lowest-numbered idle slot to that connection and answers "confirmed". When no slot is idle, it answers "denied". A deactivation releases the slot bound to the connection, and the answer is always "confirmed", whether or not the connection held a slot.

Requests enter through a valid/ready handshake, and the block accepts only one at a time. Each answer appears on a one-cycle response strobe together with the slot number involved. A combinational lookup port returns the owning connection of any slot, and an occupancy output gives the number of slots in use. The slot table is a set of registers with one compare per slot. The whole table is searched in a single cycle, so every request finishes in a fixed three-cycle turn.

Top module: `pm_pool_alloc`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `busy_count` is 0, and `lu_valid` is 0 for every slot.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. In the cycle after that edge, `req_ready` is 0. In the cycle after that, `rsp_valid` is 1 for exactly one cycle. In the cycle after the strobe, `req_ready` is 1 again. With no request taken, `rsp_valid` stays 0.
- R3: An activation (`req_op` = 0) for a connection that holds no slot, made while a slot is idle, answers `rsp_granted` = 1. The answer carries in `rsp_slot` the lowest-numbered idle slot. Afterwards the lookup of that slot shows `lu_valid` = 1 and `lu_conn` equal to the connection.
- R4: An activation made while all NUM_SLOTS (default 128) slots are in use answers `rsp_granted` = 0. The slot table and `busy_count` stay unchanged.
- R5: An activation for a connection that already holds a slot answers `rsp_granted` = 1 with that same slot in `rsp_slot`. No further slot is allocated.
- R6: A deactivation (`req_op` = 1) for a connection that holds a slot answers `rsp_granted` = 1 with that slot in `rsp_slot`. It marks the slot idle and lowers `busy_count` by one.
- R7: A deactivation for a connection that holds no slot answers `rsp_granted` = 1 and `rsp_slot` = 0. The slot table and `busy_count` stay unchanged.
- R8: `busy_count` always equals the number of slots whose lookup shows `lu_valid` = 1. It changes only in the cycle in which `rsp_valid` is 1.
- R9: A slot freed by deactivation is handed out again by a later activation, provided it is then the lowest-numbered idle slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Allocator can take a request |
| req_op | input | 1 | 0 = activate, 1 = deactivate |
| req_conn | input | CONN_W | Connection index of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_op | output | 1 | Operation being answered (0 = activate, 1 = deactivate) |
| rsp_granted | output | 1 | 1 = confirmed, 0 = denied |
| rsp_slot | output | SLOT_W | Slot granted, found or freed (0 when none) |
| lu_slot | input | SLOT_W | Slot to look up |
| lu_valid | output | 1 | Looked-up slot is in use |
| lu_conn | output | CONN_W | Connection owning the looked-up slot |
| busy_count | output | CNT_W | Number of occupied slots |

## Verification
A request taken at rising edge k yields the following results. `req_ready` is low in the cycle after edge k. `rsp_valid`, `rsp_granted`, `rsp_slot` and the updated `busy_count` and lookup contents are all present in the cycle after edge k+1. `req_ready` returns in the cycle after edge k+2. The bench drives inputs at falling edges and samples every result at the falling edge inside the cycle where that result is due. Each answer is therefore checked in the cycle it is due, and a result that arrives early or late is seen as a mismatch. Expected grants, slot numbers and occupancy come from a slot model kept in the bench, which applies the lowest-index and already-held rules from the requirements.

// File: rtl/pm_pool_pkg.sv
package pm_pool_pkg;
  // request operation encoding, shared by bench-facing ports
  typedef enum logic {
    OP_ACT   = 1'b0,
    OP_DEACT = 1'b1
  } pm_op_e;

  // controller phases: wait, search table, present answer
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_DONE = 2'd2
  } pm_state_e;
endpackage

// File: rtl/pm_prio_enc.sv
module pm_prio_enc #(
  parameter int N     = 128,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins: scan from the top so lower indices overwrite
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pm_slot_table.sv
module pm_slot_table #(
  parameter int N      = 128,
  parameter int CONN_W = 12,
  parameter int IDX_W  = $clog2(N),
  parameter int CNT_W  = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CONN_W-1:0] wr_conn,
  input  logic [CONN_W-1:0] cmp_conn,
  output logic [N-1:0]      match_vec,
  output logic [N-1:0]      free_vec,
  input  logic [IDX_W-1:0]  lu_idx,
  output logic              lu_valid,
  output logic [CONN_W-1:0] lu_conn,
  output logic [CNT_W-1:0]  busy_count
);
  logic [N-1:0]      vld_q, vld_d;
  logic [CONN_W-1:0] owner_q [N];
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // next state of the occupancy bits and counter
  always_comb begin
    vld_d = vld_q;
    cnt_d = cnt_q;
    if (set_en) begin
      vld_d[wr_idx] = 1'b1;
      cnt_d         = cnt_q + CNT_W'(1);
    end else if (clr_en) begin
      vld_d[wr_idx] = 1'b0;
      cnt_d         = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else if (set_en || clr_en) begin
      vld_q <= vld_d;
      cnt_q <= cnt_d;
    end
  end

  // one owner register and one comparator per slot
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic wr_here;
    assign wr_here = set_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       owner_q[g] <= '0;
      else if (wr_here) owner_q[g] <= wr_conn;
    end

    assign match_vec[g] = vld_q[g] && (owner_q[g] == cmp_conn);
    assign free_vec[g]  = !vld_q[g];
  end

  assign lu_valid   = vld_q[lu_idx];
  assign lu_conn    = owner_q[lu_idx];
  assign busy_count = cnt_q;
endmodule

// File: rtl/pm_pool_ctrl.sv
module pm_pool_ctrl
  import pm_pool_pkg::*;
#(
  parameter int CONN_W = 12,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [CONN_W-1:0] req_conn,
  input  logic              hit_any,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic              free_any,
  input  logic [IDX_W-1:0]  free_idx,
  output logic [CONN_W-1:0] cmp_conn,
  output logic              set_en,
  output logic              clr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              rsp_valid,
  output logic              rsp_op,
  output logic              rsp_granted,
  output logic [IDX_W-1:0]  rsp_slot
);
  pm_state_e         st_q, st_d;
  logic              op_q;
  logic [CONN_W-1:0] conn_q;
  logic              take;
  logic              rv_q, rv_d;
  logic              rg_q, rg_d;
  logic [IDX_W-1:0]  rs_q, rs_d;
  logic              ans_en;

  assign req_ready = (st_q == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign ans_en    = (st_q == ST_LOOK);

  // next state and decision made from the table search
  always_comb begin
    st_d   = st_q;
    rv_d   = 1'b0;
    rg_d   = rg_q;
    rs_d   = rs_q;
    set_en = 1'b0;
    clr_en = 1'b0;
    wr_idx = '0;
    unique case (st_q)
      ST_IDLE: if (take) st_d = ST_LOOK;
      ST_LOOK: begin
        st_d = ST_DONE;
        rv_d = 1'b1;
        if (op_q == OP_ACT) begin
          if (hit_any) begin
            rg_d = 1'b1;
            rs_d = hit_idx;
          end else if (free_any) begin
            rg_d   = 1'b1;
            rs_d   = free_idx;
            set_en = 1'b1;
            wr_idx = free_idx;
          end else begin
            rg_d = 1'b0;
            rs_d = '0;
          end
        end else begin
          rg_d = 1'b1;
          rs_d = hit_any ? hit_idx : '0;
          if (hit_any) begin
            clr_en = 1'b1;
            wr_idx = hit_idx;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
    end
  end

  // request capture register, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= 1'b0;
      conn_q <= '0;
    end else if (take) begin
      op_q   <= req_op;
      conn_q <= req_conn;
    end
  end

  // answer register, enabled in the search phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rg_q <= 1'b0;
      rs_q <= '0;
    end else if (ans_en) begin
      rg_q <= rg_d;
      rs_q <= rs_d;
    end
  end

  assign cmp_conn    = conn_q;
  assign rsp_valid   = rv_q;
  assign rsp_op      = op_q;
  assign rsp_granted = rg_q;
  assign rsp_slot    = rs_q;
endmodule

// File: rtl/pm_pool_alloc.sv
module pm_pool_alloc #(
  parameter int NUM_SLOTS = 128,
  parameter int CONN_W    = 12,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [CONN_W-1:0] req_conn,
  output logic              rsp_valid,
  output logic              rsp_op,
  output logic              rsp_granted,
  output logic [SLOT_W-1:0] rsp_slot,
  input  logic [SLOT_W-1:0] lu_slot,
  output logic              lu_valid,
  output logic [CONN_W-1:0] lu_conn,
  output logic [CNT_W-1:0]  busy_count
);
  logic [NUM_SLOTS-1:0] match_vec, free_vec;
  logic                 hit_any, free_any;
  logic [SLOT_W-1:0]    hit_idx, free_idx, wr_idx;
  logic [CONN_W-1:0]    cmp_conn;
  logic                 set_en, clr_en;

  pm_slot_table #(.N(NUM_SLOTS), .CONN_W(CONN_W), .IDX_W(SLOT_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
    .wr_idx(wr_idx), .wr_conn(cmp_conn), .cmp_conn(cmp_conn),
    .match_vec(match_vec), .free_vec(free_vec),
    .lu_idx(lu_slot), .lu_valid(lu_valid), .lu_conn(lu_conn),
    .busy_count(busy_count)
  );

  pm_prio_enc #(.N(NUM_SLOTS), .IDX_W(SLOT_W)) u_hit_enc (
    .vec(match_vec), .any(hit_any), .idx(hit_idx)
  );

  pm_prio_enc #(.N(NUM_SLOTS), .IDX_W(SLOT_W)) u_free_enc (
    .vec(free_vec), .any(free_any), .idx(free_idx)
  );

  pm_pool_ctrl #(.CONN_W(CONN_W), .IDX_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_conn(req_conn),
    .hit_any(hit_any), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx),
    .cmp_conn(cmp_conn), .set_en(set_en), .clr_en(clr_en), .wr_idx(wr_idx),
    .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_granted(rsp_granted), .rsp_slot(rsp_slot)
  );
endmodule

// File: rtl/pm_pool_alloc_chk.sv
module pm_pool_alloc_chk #(
  parameter int NUM_SLOTS = 128,
  parameter int SLOT_W    = 7,
  parameter int CNT_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_op,
  input logic              rsp_granted,
  input logic [CNT_W-1:0]  busy_count
);
  // R2
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 rsp_valid);

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  deny_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_granted) |-> (busy_count == CNT_W'(NUM_SLOTS)));

  // R6 R7
  deact_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_op) |-> rsp_granted);

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_count <= CNT_W'(NUM_SLOTS));

  // R8
  count_moves_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_count != $past(busy_count)) |-> rsp_valid);
endmodule

bind pm_pool_alloc pm_pool_alloc_chk #(
  .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_granted(rsp_granted),
  .busy_count(busy_count)
);

// File: tb/pm_pool_alloc_tb.sv
module pm_pool_alloc_tb;
  localparam int N      = 128;
  localparam int CONN_W = 12;
  localparam int SLOT_W = $clog2(N);
  localparam int CNT_W  = $clog2(N + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_op;
  logic [CONN_W-1:0] req_conn;
  logic              req_ready, rsp_valid, rsp_op, rsp_granted;
  logic [SLOT_W-1:0] rsp_slot, lu_slot;
  logic              lu_valid;
  logic [CONN_W-1:0] lu_conn;
  logic [CNT_W-1:0]  busy_count;

  int checks = 0;
  int fails  = 0;

  // bench slot model
  bit          m_vld  [N];
  int unsigned m_conn [N];
  int          m_cnt = 0;

  always #10 clk = ~clk;

  pm_pool_alloc #(.NUM_SLOTS(N), .CONN_W(CONN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_conn(req_conn), .rsp_valid(rsp_valid), .rsp_op(rsp_op),
    .rsp_granted(rsp_granted), .rsp_slot(rsp_slot), .lu_slot(lu_slot),
    .lu_valid(lu_valid), .lu_conn(lu_conn), .busy_count(busy_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // walk every slot through the lookup port and compare with the model
  task automatic scan_table(input string req);
    int bad = 0;
    for (int s = 0; s < N; s++) begin
      @(negedge clk);
      lu_slot = SLOT_W'(s);
      #1;
      if (lu_valid !== m_vld[s]) bad++;
      else if (m_vld[s] && (int'(lu_conn) != int'(m_conn[s]))) bad++;
    end
    check(bad == 0, req, "table mismatches", bad, 0);
  endtask

  // issue one request, compute the expected answer from the model, check timing and fields
  task automatic do_req(input bit op, input int unsigned conn, input string req);
    int  hit = -1, fre = -1, exp_slot;
    bit  exp_g;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_vld[i] && m_conn[i] == conn) hit = i;
      if (!m_vld[i]) fre = i;
    end
    if (op == 1'b0) begin
      if (hit >= 0)      begin exp_g = 1; exp_slot = hit; end
      else if (fre >= 0) begin exp_g = 1; exp_slot = fre; end
      else               begin exp_g = 0; exp_slot = 0;   end
    end else begin
      exp_g = 1; exp_slot = (hit >= 0) ? hit : 0;
    end
    check(req_ready === 1'b1, "R2", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_conn = CONN_W'(conn);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready === 1'b0 && rsp_valid === 1'b0, "R2", "stall after accept",
          int'({req_ready, rsp_valid}), 0);
    // model update takes effect with the response
    if (op == 1'b0 && hit < 0 && fre >= 0) begin m_vld[fre] = 1; m_conn[fre] = conn; m_cnt++; end
    if (op == 1'b1 && hit >= 0) begin m_vld[hit] = 0; m_cnt--; end
    @(negedge clk);
    check(rsp_valid === 1'b1, "R2", "response strobe", int'(rsp_valid), 1);
    check(rsp_granted === exp_g, req, "granted", int'(rsp_granted), int'(exp_g));
    check(int'(rsp_slot) == exp_slot, req, "slot", int'(rsp_slot), exp_slot);
    check(int'(busy_count) == m_cnt, "R8", "busy count", int'(busy_count), m_cnt);
    @(negedge clk);
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R2", "strobe ends, ready back",
          int'({rsp_valid, req_ready}), 1);
  endtask

  task automatic t_reset;
    // R1
    check(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    check(rsp_valid === 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
    check(busy_count == '0, "R1", "count after reset", int'(busy_count), 0);
    scan_table("R1");
  endtask

  task automatic t_idle;
    // R2: no request, no response
    int seen = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (rsp_valid !== 1'b0) seen++;
    end
    check(seen == 0, "R2", "idle responses", seen, 0);
  endtask

  task automatic t_basic;
    do_req(1'b0, 12'h010, "R3");
    scan_table("R3");
    do_req(1'b0, 12'h010, "R5");
    do_req(1'b0, 12'h022, "R3");
    do_req(1'b1, 12'h010, "R6");
    scan_table("R6");
    do_req(1'b1, 12'h999, "R7");
    scan_table("R7");
    do_req(1'b0, 12'h033, "R9");
  endtask

  task automatic t_fill;
    int unsigned c = 12'h100;
    while (m_cnt < N) begin
      do_req(1'b0, c, "R3");
      c++;
    end
    check(int'(busy_count) == N, "R4", "pool full", int'(busy_count), N);
    do_req(1'b0, 12'h7FF, "R4");
    scan_table("R4");
    do_req(1'b0, m_conn[90], "R5");
    do_req(1'b1, m_conn[57], "R6");
    do_req(1'b0, 12'h6AA, "R9");
    scan_table("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) begin m_vld[s] = 0; m_conn[s] = 0; end
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_conn = '0; lu_slot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_basic();
    t_fill();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule